// File: doc/BRIEF.md
# ATA PIO Command Sequencer

This block is a host-side controller that carries out one multi-sector PIO data command against an ATA device. The control side gives it a 28-bit start LBA, an 8-bit sector count, a command byte, the transfer direction, the device number and a flag that says whether the current timing mode is faster than PIO mode 2. A one-cycle `start` pulse then launches the whole sequence. The sequencer waits for the device to report ready, enables the device interrupt and programs the task-file registers in the order the device expects. After issuing the command it moves 16-bit words one sector at a time.

The device side is a simplified task-file bus. There is a 4-bit register address, read and write strobes, and a 16-bit data path in each direction. During a read strobe the device returns `tf_rdata` in the same cycle. Each sector is gated by the device interrupt. The primary status register is read once to acknowledge that interrupt, and every other status poll goes to the alternate status register, which clears nothing. Data words move only while the device reports a data request. When the timing mode is fast, each data access is stretched until the device signals ready.

The run ends in one of three ways:
- a one-cycle `done` pulse;
- a sticky `error` flag, with the offending status byte held in `err_status`;
- a sticky `timeout` flag, raised if the device stays busy too long.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `timeout` are low and neither `tf_rd` nor `tf_wr` is asserted.
- R2: No task-file register is written until a status read shows BSY (bit 7) clear and DRDY (bit 6) set. Ready polling reads the alternate status at address 14.
- R3: The register writes of a command follow this order, with the command register written last:
  - 16'h0000 to address 14 (device control, interrupt-disable bit 1 cleared);
  - the sector count to address 2;
  - LBA bits 7:0, 15:8 and 23:16 to addresses 3, 4 and 5;
  - 8'hE0 | (device << 4) | LBA[27:24] to address 6;
  - the command byte to address 7.
- R4: A sector count of 0 transfers 256 sectors.
- R5: Each sector waits for `intrq`. The primary status at address 7 is then read exactly once, so the number of such reads equals the number of sectors.
- R6: Data accesses go to address 0 only after a status read showed DRQ (bit 3) set, and each sector carries WORDS words:
  - read words appear on `rd_data` qualified by `rd_valid`;
  - write words are taken from `wr_data`, and each taken word is acknowledged by `wr_take`.
- R7: With `fast_pio` high, a data strobe is held until `iordy` is high. With `fast_pio` low, every data access lasts one cycle whatever `iordy` does.
- R8: If DRQ drops after a word count other than WORDS, or is still set once WORDS words have moved, the sequencer sets `error`, captures that status byte and returns to idle.
- R9: If any status read shows ERR (bit 0) or DF (bit 5), the sequencer sets `error`, captures that status byte in `err_status` and returns to idle without `done`.
- R10: If BSY is seen continuously for LIMIT_SEC × TICKS_PER_SEC cycles after the command is issued, the sequencer sets `timeout`, returns to idle and gives no `done`.
- R11: After the last sector, the sequencer polls until BSY and DRQ are both clear, then pulses `done` for exactly one cycle as `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| lba | input | 28 | Start logical block address |
| count | input | 8 | Sector count, 0 means 256 |
| cmd | input | 8 | Command byte |
| write_dir | input | 1 | 1 = host to device |
| fast_pio | input | 1 | Timing mode above PIO 2; enables IORDY stretching |
| dev_sel | input | 1 | Device number placed in bit 4 of the device/head register |
| wr_data | input | 16 | Next word to write |
| wr_take | output | 1 | A write word was consumed this cycle |
| rd_data | output | 16 | Word read from the device |
| rd_valid | output | 1 | `rd_data` holds a data word this cycle |
| tf_addr | output | 4 | Task-file register address |
| tf_rd | output | 1 | Register read strobe |
| tf_wr | output | 1 | Register write strobe |
| tf_wdata | output | 16 | Register write data |
| tf_rdata | input | 16 | Register read data, valid in the strobe cycle |
| iordy | input | 1 | Device ready for the current data access |
| intrq | input | 1 | Device interrupt request |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | Sticky error flag, cleared by the next start |
| timeout | output | 1 | Sticky timeout flag, cleared by the next start |
| err_status | output | 8 | Status byte that caused the error |

## Verification
The embedded properties rely on the device answering a read in the same cycle as the strobe. They also rely on `iordy` eventually rising during a stretched access, and on `start` being pulsed only while `busy` is low. The bench's device model respects all three:
- its status and data are combinational functions of its registered state;
- it releases `iordy` after a bounded stall of at most three cycles;
- the bench pulses `start` only after `busy` has dropped.

Faults are injected only as the device would report them: ERR or DF in status, a short sector, or a device that never clears BSY.

// File: rtl/ata_pio_seq.sv
module ata_pio_seq #(
  parameter int WORDS         = 256,
  parameter int TICKS_PER_SEC = 50_000_000,
  parameter int LIMIT_SEC     = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [27:0] lba,
  input  logic [7:0]  count,
  input  logic [7:0]  cmd,
  input  logic        write_dir,
  input  logic        fast_pio,
  input  logic        dev_sel,
  input  logic [15:0] wr_data,
  output logic        wr_take,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic [3:0]  tf_addr,
  output logic        tf_rd,
  output logic        tf_wr,
  output logic [15:0] tf_wdata,
  input  logic [15:0] tf_rdata,
  input  logic        iordy,
  input  logic        intrq,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        timeout,
  output logic [7:0]  err_status
);
  localparam int WCW = $clog2(WORDS + 1);
  localparam int PW  = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int SW  = $clog2(LIMIT_SEC + 1);
  localparam logic [WCW-1:0] W_FULL = WCW'(WORDS);
  localparam logic [PW-1:0]  P_LAST = PW'(TICKS_PER_SEC - 1);
  localparam logic [SW-1:0]  S_LAST = SW'(LIMIT_SEC - 1);
  localparam logic [3:0] A_DATA = 4'd0, A_CNT = 4'd2, A_LBA0 = 4'd3, A_LBA1 = 4'd4,
                         A_LBA2 = 4'd5, A_DEV = 4'd6, A_CMD = 4'd7, A_ALT = 4'd14;

  typedef enum logic [2:0] {IDLE, READY, PROG, WAIT_IRQ, ACK, CHECK, XFER, FINISH} st_t;
  st_t st;

  logic [2:0]     step;
  logic [8:0]     left;
  logic [WCW-1:0] wcnt;
  logic [PW-1:0]  pre;
  logic [SW-1:0]  secs;
  logic [27:0]    q_lba;
  logic [7:0]     q_cnt, q_cmd;
  logic           q_wr, q_fast, q_dev, rdy_ok, drq_q;

  wire [7:0] stat    = tf_rdata[7:0];
  wire       bsy     = stat[7];
  wire       drdy    = stat[6];
  wire       drq     = stat[3];
  wire       bad     = stat[0] | stat[5];
  wire       polling = (st == READY) || (st == WAIT_IRQ) || (st == ACK) ||
                       (st == CHECK) || (st == FINISH);
  wire       go      = !q_fast || iordy;
  wire       tmr_run = ((st == WAIT_IRQ) || (st == FINISH)) && bsy;
  wire       expire  = tmr_run && (pre == P_LAST) && (secs == S_LAST);

  assign busy     = (st != IDLE);
  assign rd_data  = tf_rdata;
  assign rd_valid = (st == XFER) && go && !q_wr;
  assign wr_take  = (st == XFER) && go && q_wr;

  always_comb begin
    tf_addr  = A_ALT;
    tf_rd    = 1'b0;
    tf_wr    = 1'b0;
    tf_wdata = 16'h0000;
    case (st)
      READY, WAIT_IRQ, CHECK, FINISH: tf_rd = 1'b1;
      ACK: begin tf_rd = 1'b1; tf_addr = A_CMD; end
      PROG: begin
        tf_wr = 1'b1;
        case (step)
          3'd0:    begin tf_addr = A_ALT;  tf_wdata = 16'h0000; end
          3'd1:    begin tf_addr = A_CNT;  tf_wdata = {8'h00, q_cnt}; end
          3'd2:    begin tf_addr = A_LBA0; tf_wdata = {8'h00, q_lba[7:0]}; end
          3'd3:    begin tf_addr = A_LBA1; tf_wdata = {8'h00, q_lba[15:8]}; end
          3'd4:    begin tf_addr = A_LBA2; tf_wdata = {8'h00, q_lba[23:16]}; end
          3'd5:    begin tf_addr = A_DEV;  tf_wdata = {8'h00, 3'b111, q_dev, q_lba[27:24]}; end
          default: begin tf_addr = A_CMD;  tf_wdata = {8'h00, q_cmd}; end
        endcase
      end
      XFER: begin
        tf_addr  = A_DATA;
        tf_rd    = !q_wr;
        tf_wr    = q_wr;
        tf_wdata = wr_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; step <= '0; left <= '0; wcnt <= '0; pre <= '0; secs <= '0;
      q_lba <= '0; q_cnt <= '0; q_cmd <= '0; q_wr <= 1'b0; q_fast <= 1'b0; q_dev <= 1'b0;
      rdy_ok <= 1'b0; drq_q <= 1'b0;
      done <= 1'b0; error <= 1'b0; timeout <= 1'b0; err_status <= '0;
    end else begin
      done <= 1'b0;
      if (!tmr_run) begin
        pre <= '0; secs <= '0;
      end else if (pre == P_LAST) begin
        pre <= '0; secs <= secs + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      if (st == CHECK) drq_q <= drq;

      if (polling && bad) begin
        error <= 1'b1; err_status <= stat; st <= IDLE;
      end else begin
        case (st)
          IDLE: if (start) begin
            q_lba <= lba; q_cnt <= count; q_cmd <= cmd; q_wr <= write_dir;
            q_fast <= fast_pio; q_dev <= dev_sel;
            error <= 1'b0; timeout <= 1'b0; err_status <= '0; rdy_ok <= 1'b0;
            left <= (count == 8'd0) ? 9'd256 : {1'b0, count};
            st <= READY;
          end
          READY: if (!bsy && drdy) begin
            rdy_ok <= 1'b1; step <= '0; st <= PROG;
          end
          PROG: begin
            step <= step + 1'b1;
            if (step == 3'd6) st <= WAIT_IRQ;
          end
          WAIT_IRQ: begin
            if (expire) begin timeout <= 1'b1; st <= IDLE; end
            else if (intrq) st <= ACK;
          end
          ACK: begin wcnt <= '0; st <= CHECK; end
          CHECK: begin
            if (drq) begin
              if (wcnt == W_FULL) begin error <= 1'b1; err_status <= stat; st <= IDLE; end
              else st <= XFER;
            end else if (wcnt != W_FULL) begin
              error <= 1'b1; err_status <= stat; st <= IDLE;
            end else if (left == 9'd1) begin
              st <= FINISH;
            end else begin
              left <= left - 1'b1; st <= WAIT_IRQ;
            end
          end
          XFER: if (go) begin wcnt <= wcnt + 1'b1; st <= CHECK; end
          FINISH: begin
            if (expire) begin timeout <= 1'b1; st <= IDLE; end
            else if (!bsy && !drq) begin done <= 1'b1; st <= IDLE; end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  iordy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tf_rd || tf_wr) && tf_addr == A_DATA && q_fast && !iordy)
      |=> ((tf_rd || tf_wr) && tf_addr == A_DATA));
  // R2
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_wr && tf_addr == A_CMD) |-> rdy_ok);
  // R6
  data_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tf_rd || tf_wr) && tf_addr == A_DATA) |-> drq_q);
  // R10
  timeout_bsy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(tf_rd && tf_rdata[7]));
  // R9
  error_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> !busy);
endmodule

// File: tb/ata_pio_seq_tb_top.sv
module ata_pio_seq_tb_top;
  localparam int W   = 8;
  localparam int TK  = 4;
  localparam int LIM = 31;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, write_dir, fast_pio, dev_sel;
  logic [27:0] lba;
  logic [7:0]  count, cmd;
  logic [15:0] wr_data, rd_data, tf_wdata, tf_rdata;
  logic        wr_take, rd_valid, tf_rd, tf_wr, iordy, intrq;
  logic        busy, done, error, timeout;
  logic [3:0]  tf_addr;
  logic [7:0]  err_status;

  ata_pio_seq #(.WORDS(W), .TICKS_PER_SEC(TK), .LIMIT_SEC(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .lba(lba), .count(count), .cmd(cmd),
    .write_dir(write_dir), .fast_pio(fast_pio), .dev_sel(dev_sel),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .tf_addr(tf_addr), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .iordy(iordy), .intrq(intrq), .busy(busy), .done(done),
    .error(error), .timeout(timeout), .err_status(err_status));

  function automatic logic [15:0] pat(input int s, input int w);
    pat = 16'(s * 37 + w * 5) ^ 16'h5A00;
  endfunction

  // device model
  logic dclr;
  int   k_busy0, k_stall, k_fault;
  logic k_fast;
  int   b0cnt, dly, ph, sec_i, w_i, nsec_dev, stall_n;
  int   wlog_n, prim, wmis, wtot, bad_wr;
  logic bsy_r, d_drq, d_err, d_df, d_irq;
  logic [3:0]  wlog_a [8];
  logic [15:0] wlog_d [8];

  wire dstat_bsy = (b0cnt != 0) || bsy_r;
  wire data_acc  = (tf_rd || tf_wr) && tf_addr == 4'd0;
  assign iordy   = (stall_n >= k_stall);
  wire comp      = data_acc && (iordy || !k_fast);
  assign intrq   = d_irq;

  always_comb begin
    if (tf_addr == 4'd0) tf_rdata = pat(sec_i, w_i);
    else tf_rdata = {8'h00, dstat_bsy, 1'b1, d_df, 1'b0, d_drq, 2'b00, d_err};
  end

  always @(posedge clk) begin
    if (dclr) begin
      b0cnt <= k_busy0; bsy_r <= 1'b0; d_drq <= 1'b0; d_err <= 1'b0; d_df <= 1'b0;
      d_irq <= 1'b0; ph <= 0; sec_i <= 0; w_i <= 0; nsec_dev <= 1; stall_n <= 0; dly <= 0;
      wlog_n <= 0; prim <= 0; wmis <= 0; wtot <= 0; bad_wr <= 0;
    end else begin
      if (b0cnt != 0) b0cnt <= b0cnt - 1;
      stall_n <= (data_acc && !iordy) ? stall_n + 1 : 0;
      if (tf_wr && tf_addr != 4'd0) begin
        if (wlog_n < 8) begin wlog_a[wlog_n] <= tf_addr; wlog_d[wlog_n] <= tf_wdata; end
        wlog_n <= wlog_n + 1;
        if (dstat_bsy) bad_wr <= bad_wr + 1;
        if (tf_addr == 4'd2) nsec_dev <= (tf_wdata[7:0] == 8'd0) ? 256 : int'(tf_wdata[7:0]);
        if (tf_addr == 4'd7) begin
          if (k_fault == 2) d_err <= 1'b1;
          else if (k_fault == 4) d_df <= 1'b1;
          else begin bsy_r <= 1'b1; dly <= 3; ph <= 1; end
        end
      end
      if (tf_rd && tf_addr == 4'd7) begin d_irq <= 1'b0; prim <= prim + 1; end
      case (ph)
        1: if (k_fault != 3) begin
          if (dly == 0) begin bsy_r <= 1'b0; d_drq <= 1'b1; d_irq <= 1'b1; w_i <= 0; ph <= 2; end
          else dly <= dly - 1;
        end
        2: if (comp) begin
          w_i <= w_i + 1; wtot <= wtot + 1;
          if (tf_wr && tf_wdata != pat(sec_i, w_i)) wmis <= wmis + 1;
          if (w_i + 1 == ((k_fault == 1 && sec_i == nsec_dev - 1) ? W - 1 : W)) begin
            d_drq <= 1'b0; bsy_r <= 1'b1; dly <= 2; sec_i <= sec_i + 1; ph <= 3;
          end
        end
        3: if (dly == 0) begin
          bsy_r <= 1'b0;
          if (sec_i == nsec_dev) ph <= 0;
          else begin d_drq <= 1'b1; d_irq <= 1'b1; w_i <= 0; ph <= 2; end
        end else dly <= dly - 1;
        default: ;
      endcase
    end
  end

  // monitors
  int rd_n, rd_mis, take_n, done_cnt, run, max_run;
  assign wr_data = pat(take_n / W, take_n % W);
  always @(posedge clk) begin
    if (dclr) begin
      rd_n <= 0; rd_mis <= 0; take_n <= 0; done_cnt <= 0; run <= 0; max_run <= 0;
    end else begin
      if (rd_valid) begin
        if (rd_data != pat(rd_n / W, rd_n % W)) rd_mis <= rd_mis + 1;
        rd_n <= rd_n + 1;
      end
      if (wr_take) take_n <= take_n + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (data_acc) begin
        run <= run + 1;
        if (run + 1 > max_run) max_run <= run + 1;
      end else run <= 0;
    end
  end

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int cyc_all = 0;
  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all == 190000) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc_all, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  int last_cyc;
  task automatic run_cmd(input int cnt, input bit wr, input bit fast, input int stall,
                         input int b0, input int fault, input logic [27:0] l,
                         input bit dv, input logic [7:0] c);
    @(negedge clk);
    k_busy0 = b0; k_stall = stall; k_fault = fault; k_fast = fast; dclr = 1'b1;
    @(negedge clk);
    dclr = 1'b0;
    lba = l; count = 8'(cnt); cmd = c; write_dir = wr; fast_pio = fast; dev_sel = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    last_cyc = 1;
    while (busy && last_cyc < 60000) begin @(negedge clk); last_cyc++; end
    repeat (3) @(negedge clk);
  endtask

  // {cnt, wr, fast, stall, busy0, fault, exp_done, exp_err, exp_tmo, exp_stat}
  // fault: 0 none, 1 short last sector, 2 ERR at command, 3 BSY forever, 4 DF at command
  localparam logic [33:0] VEC [9] = '{
    {8'd1, 1'b0, 1'b0, 2'd0, 8'd5, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'd3, 1'b1, 1'b0, 2'd0, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'd2, 1'b0, 1'b1, 2'd2, 8'd3, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'd2, 1'b1, 1'b1, 2'd1, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'd2, 1'b0, 1'b0, 2'd0, 8'd0, 3'd1, 1'b0, 1'b1, 1'b0, 8'hC0},
    {8'd1, 1'b1, 1'b0, 2'd0, 8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 8'h41},
    {8'd1, 1'b0, 1'b0, 2'd0, 8'd0, 3'd3, 1'b0, 1'b0, 1'b1, 8'h00},
    {8'd2, 1'b0, 1'b0, 2'd3, 8'd0, 3'd4, 1'b0, 1'b1, 1'b0, 8'h60},
    {8'd1, 1'b0, 1'b0, 2'd2, 8'd20, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  initial begin
    dclr = 1'b1; k_busy0 = 0; k_stall = 0; k_fault = 0; k_fast = 1'b0;
    start = 1'b0; lba = '0; count = '0; cmd = '0; write_dir = 1'b0; fast_pio = 1'b0; dev_sel = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !done && !error && !timeout, "R1", "flags after reset",
        {busy, done, error, timeout}, 0);
    chk(!tf_rd && !tf_wr, "R1", "strobes after reset", {tf_rd, tf_wr}, 0);

    for (int i = 0; i < 9; i++) begin
      int  cnt, stall, fault;
      bit  wr, fast, edone, eerr, etmo;
      logic [7:0] estat;
      string rq;
      cnt = int'(VEC[i][33:26]); wr = VEC[i][25]; fast = VEC[i][24];
      stall = int'(VEC[i][23:22]); fault = int'(VEC[i][13:11]);
      edone = VEC[i][10]; eerr = VEC[i][9]; etmo = VEC[i][8]; estat = VEC[i][7:0];
      run_cmd(cnt, wr, fast, stall, int'(VEC[i][21:14]), fault, 28'h0001234, 1'b0, wr ? 8'h30 : 8'h20);
      rq = (fault == 1) ? "R8" : "R9";
      chk(done_cnt == int'(edone), "R11", $sformatf("done pulses vec %0d", i), done_cnt, int'(edone));
      chk(error == eerr, rq, $sformatf("error flag vec %0d", i), int'(error), int'(eerr));
      chk(timeout == etmo, "R10", $sformatf("timeout flag vec %0d", i), int'(timeout), int'(etmo));
      chk(!busy, "R11", $sformatf("idle after vec %0d", i), int'(busy), 0);
      if (eerr) chk(err_status == estat, rq, $sformatf("err_status vec %0d", i), err_status, estat);
      if (etmo) chk(last_cyc >= 120 && last_cyc <= 145, "R10", "cycles to timeout", last_cyc, 133);
      if (edone) begin
        chk((wr ? wtot : rd_n) == cnt * W, "R6", $sformatf("words vec %0d", i),
            wr ? wtot : rd_n, cnt * W);
        chk((wr ? wmis : rd_mis) == 0, "R6", $sformatf("data mismatches vec %0d", i),
            wr ? wmis : rd_mis, 0);
        chk(prim == cnt, "R5", $sformatf("primary status reads vec %0d", i), prim, cnt);
        chk(bad_wr == 0, "R2", $sformatf("writes while busy vec %0d", i), bad_wr, 0);
        chk(max_run == (fast ? stall + 1 : 1), "R7", $sformatf("data strobe length vec %0d", i),
            max_run, fast ? stall + 1 : 1);
      end
    end

    // R3: register programming order and values
    run_cmd(5, 1'b0, 1'b0, 0, 4, 0, 28'hA3C2F15, 1'b1, 8'h20);
    chk(wlog_n == 7, "R3", "register write count", wlog_n, 7);
    begin
      logic [3:0]  ea [7];
      logic [15:0] ed [7];
      ea = '{4'd14, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7};
      ed = '{16'h0000, 16'h0005, 16'h0015, 16'h002F, 16'h003C, 16'h00FA, 16'h0020};
      for (int j = 0; j < 7; j++) begin
        chk(wlog_a[j] == ea[j], "R3", $sformatf("address of write %0d", j), wlog_a[j], ea[j]);
        chk(wlog_d[j] == ed[j], "R3", $sformatf("data of write %0d", j), wlog_d[j], ed[j]);
      end
    end
    chk(done_cnt == 1, "R11", "done after ordered run", done_cnt, 1);

    // R4: count 0 means 256 sectors
    run_cmd(0, 1'b0, 1'b0, 0, 0, 0, 28'h0000100, 1'b0, 8'h20);
    chk(rd_n == 256 * W, "R4", "words for count 0", rd_n, 256 * W);
    chk(prim == 256, "R4", "sectors for count 0", prim, 256);
    chk(rd_mis == 0 && done_cnt == 1, "R4", "clean finish for count 0", rd_mis, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule